// File: doc/BRIEF.md
# Wrapping screen address generator

This block produces the memory read address for a bitmap display whose frame buffer wraps inside a window that depends on the display mode. Software programs a screen start address and a mode number through a small write-only register port. Every pixel clock, the raster generator supplies the timing inputs: horizontal count, hsync, frame-end line, last line of a character row, and the character row index. The block keeps two addresses: a byte address that walks across the scanline, and a row-start address that each scanline of a character row restarts from.

The byte address advances in steps of 8 within the active width. In the 80-column modes it steps once per 8 horizontal counts. In the 40-column modes it steps once per 16 counts. When a step lands below the top window, the address folds back to a mode-specific base, so the buffer appears circular. The character row index is ORed into the low bits to form the read address.

Top module: `scrn_addr_gen`

## Requirements
- R1: After reset the start address is 0 and mode 0 is selected. With a character row index of 0, the read address is 0x0000.
- R2: The screen start is loaded into both the row-start and the byte address in a cycle with frame_end high and h_count equal to LOAD_HPOS (default 760). No other cycle performs this load.
- R3: In a cycle with hsync high, the row-start address takes the byte address if row_last is 1. If row_last is 0, the byte address is restored from the row-start address.
- R4: rd_addr equals the byte address ORed with char_row (zero-extended), without delay.
- R5: In modes 0 to 3, the byte address increases by 8 in a cycle where h_count < H_ACTIVE (default 640) and h_count[2:0] = 0.
- R6: In modes 4 to 7, the byte address increases by 8 in a cycle where h_count < H_ACTIVE and h_count[3:0] = 8.
- R7: If bits 14:11 of the sum are all zero after an increment, the address becomes the mode base ORed with bits 10:0 of the sum. This includes the carry out of 0x7FF8, which gives 0x0000.
- R8: The mode base is 0x3000 for modes 0, 1 and 2. It is 0x4000 for mode 3, 0x6000 for mode 6, and 0x5800 for modes 4, 5 and 7.
- R9: A write to offset 2 sets start bits 8:6 from data bits 7:5. A write to offset 3 sets start bits 14:9 from data bits 5:0. Each of these writes leaves the other start bits unchanged. A write to offset 7 sets the mode from data bits 5:3. Writes to other offsets change nothing. Start bits 5:0 are always 0.
- R10: A write to the start address does not move the current read address. If the write falls in the same cycle as a frame-start load, the load uses the previous start value, and the new value appears at the next load.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Pixel clock |
| rst_n | input | 1 | Active-low synchronous reset |
| reg_we | input | 1 | Register write strobe |
| reg_off | input | 4 | Register offset |
| reg_wdata | input | 8 | Register write data |
| h_count | input | HCNT_W | Horizontal position from the raster generator |
| hsync | input | 1 | Horizontal sync active |
| frame_end | input | 1 | Current line is the last line of the frame |
| row_last | input | 1 | Current line is the last line of a character row |
| char_row | input | ROW_W | Line index inside the character row |
| rd_addr | output | ADDR_W | Video memory read address |

## Verification
Two pairs of functions can fall in the same cycle. In the first pair, a register write to the start address coincides with a frame-start load. The bench drives the write strobe in the load cycle itself and expects the old start value after that edge, then the new value after the next load. In the second pair, an increment crosses the top of memory in the same step as the fold to the mode base. The bench sets the start just below 0x8000, steps under each of the eight modes, and compares the result with that mode's base.

// File: rtl/scrn_pkg.sv
package scrn_pkg;
   typedef logic [2:0] mode_t;

   localparam logic [3:0] OFF_START_LO = 4'd2;
   localparam logic [3:0] OFF_START_HI = 4'd3;
   localparam logic [3:0] OFF_MODE     = 4'd7;

   function automatic logic [14:0] mode_base(input mode_t m);
      case (m)
         3'd0, 3'd1, 3'd2: mode_base = 15'h3000;
         3'd3:             mode_base = 15'h4000;
         3'd6:             mode_base = 15'h6000;
         default:          mode_base = 15'h5800;
      endcase
   endfunction

   function automatic logic mode_is_wide(input mode_t m);
      mode_is_wide = m[2];
   endfunction
endpackage

// File: rtl/scrn_regs.sv
module scrn_regs
   import scrn_pkg::*;
#(
   parameter int ADDR_W = 15
) (
   input  logic              clk,
   input  logic              rst_n,
   input  logic              we,
   input  logic [3:0]        off,
   input  logic [7:0]        wdata,
   output logic [ADDR_W-1:0] start,
   output mode_t             mode
);
   logic [2:0] lo_q;
   logic [5:0] hi_q;
   mode_t      mode_q;

   always_ff @(posedge clk) begin
      if (!rst_n) begin
         lo_q   <= '0;
         hi_q   <= '0;
         mode_q <= '0;
      end else if (we) begin
         case (off)
            OFF_START_LO: lo_q   <= wdata[7:5];
            OFF_START_HI: hi_q   <= wdata[5:0];
            OFF_MODE:     mode_q <= wdata[5:3];
            default: ;
         endcase
      end
   end

   always_comb begin
      start        = '0;
      start[8:6]   = lo_q;
      start[14:9]  = hi_q;
   end
   assign mode = mode_q;

   // R9: a low-field write keeps the high field
   p_keep_hi_r9: assert property (@(posedge clk) disable iff (!rst_n)
      (we && off == OFF_START_LO) |=> $stable(start[14:9]));

   // R9: mode only changes on a mode write
   p_mode_hold_r9: assert property (@(posedge clk) disable iff (!rst_n)
      !(we && off == OFF_MODE) |=> $stable(mode));
endmodule

// File: rtl/scrn_mode_dec.sv
module scrn_mode_dec
   import scrn_pkg::*;
#(
   parameter int ADDR_W = 15
) (
   input  mode_t             mode,
   output logic [ADDR_W-1:0] base,
   output logic              wide
);
   localparam int PAD = ADDR_W - 15;

   generate
      if (PAD > 0) begin : g_pad
         assign base = {{PAD{1'b0}}, mode_base(mode)};
      end else begin : g_nopad
         assign base = mode_base(mode);
      end
   endgenerate

   assign wide = mode_is_wide(mode);
endmodule

// File: rtl/scrn_addr_ctr.sv
module scrn_addr_ctr #(
   parameter int ADDR_W    = 15,
   parameter int WRAP_LSB  = 11,
   parameter int STEP      = 8,
   parameter int HCNT_W    = 10,
   parameter int H_ACTIVE  = 640,
   parameter int LOAD_HPOS = 760
) (
   input  logic              clk,
   input  logic              rst_n,
   input  logic [HCNT_W-1:0] h_count,
   input  logic              hsync,
   input  logic              frame_end,
   input  logic              row_last,
   input  logic              wide,
   input  logic [ADDR_W-1:0] base,
   input  logic [ADDR_W-1:0] start,
   output logic [ADDR_W-1:0] byte_addr
);
   localparam int LOG_STEP = $clog2(STEP);
   localparam logic [HCNT_W-1:0]   ACT_LIM = H_ACTIVE[HCNT_W-1:0];
   localparam logic [HCNT_W-1:0]   LOAD_H  = LOAD_HPOS[HCNT_W-1:0];
   localparam logic [ADDR_W-1:0]   STEP_V  = STEP[ADDR_W-1:0];
   localparam logic [LOG_STEP:0]   WIDE_PH = {1'b1, {LOG_STEP{1'b0}}};

   logic [ADDR_W-1:0] byte_q, row_q;
   logic [ADDR_W-1:0] b0, r0, b1, r1, b2, sum;
   logic load, step, phase_ok;

   assign load = frame_end && (h_count == LOAD_H);
   assign phase_ok = wide ? (h_count[LOG_STEP:0] == WIDE_PH)
                          : (h_count[LOG_STEP-1:0] == '0);
   assign step = (h_count < ACT_LIM) && phase_ok;
   assign sum  = b1 + STEP_V;

   always_comb begin
      b0 = byte_q;
      r0 = row_q;
      if (load) begin
         b0 = start;
         r0 = start;
      end
      b1 = b0;
      r1 = r0;
      if (hsync) begin
         if (row_last) r1 = b0;
         else          b1 = r0;
      end
      b2 = b1;
      if (step) begin
         if (sum[ADDR_W-1:WRAP_LSB] == '0)
            b2 = base | {{(ADDR_W-WRAP_LSB){1'b0}}, sum[WRAP_LSB-1:0]};
         else
            b2 = sum;
      end
   end

   always_ff @(posedge clk) begin
      if (!rst_n) begin
         byte_q <= '0;
         row_q  <= '0;
      end else begin
         byte_q <= b2;
         row_q  <= r1;
      end
   end

   assign byte_addr = byte_q;

   // R2: a load without other activity leaves both addresses at the start
   p_load_r2: assert property (@(posedge clk) disable iff (!rst_n)
      (load && !step && !hsync) |=> (byte_q == $past(start) && row_q == $past(start)));

   // R3: restore makes byte equal the row start
   p_restore_r3: assert property (@(posedge clk) disable iff (!rst_n)
      (hsync && !row_last && !load && !step) |=> (byte_q == row_q));

   // R7: after any step the top field is never all zero
   p_wrapfield_r7: assert property (@(posedge clk) disable iff (!rst_n)
      step |=> (byte_q[ADDR_W-1:WRAP_LSB] != '0));

   // R10: with no load, hsync or step, the addresses hold
   p_hold_r10: assert property (@(posedge clk) disable iff (!rst_n)
      (!load && !hsync && !step) |=> ($stable(byte_q) && $stable(row_q)));
endmodule

// File: rtl/scrn_addr_gen.sv
module scrn_addr_gen
   import scrn_pkg::*;
#(
   parameter int ADDR_W    = 15,
   parameter int WRAP_LSB  = 11,
   parameter int STEP      = 8,
   parameter int HCNT_W    = 10,
   parameter int H_ACTIVE  = 640,
   parameter int LOAD_HPOS = 760,
   parameter int ROW_W     = 4
) (
   input  logic              clk,
   input  logic              rst_n,
   input  logic              reg_we,
   input  logic [3:0]        reg_off,
   input  logic [7:0]        reg_wdata,
   input  logic [HCNT_W-1:0] h_count,
   input  logic              hsync,
   input  logic              frame_end,
   input  logic              row_last,
   input  logic [ROW_W-1:0]  char_row,
   output logic [ADDR_W-1:0] rd_addr
);
   generate
      if (ADDR_W < 15) begin : g_bad_aw
         $error("ADDR_W must be at least 15");
      end
      if (WRAP_LSB < 1 || WRAP_LSB >= ADDR_W) begin : g_bad_wrap
         $error("WRAP_LSB out of range");
      end
      if (STEP < 2 || (STEP & (STEP - 1)) != 0) begin : g_bad_step
         $error("STEP must be a power of two");
      end
      if (H_ACTIVE >= (1 << HCNT_W) || LOAD_HPOS >= (1 << HCNT_W)) begin : g_bad_h
         $error("horizontal limits exceed HCNT_W");
      end
      if (ROW_W > ADDR_W) begin : g_bad_row
         $error("ROW_W exceeds ADDR_W");
      end
   endgenerate

   logic [ADDR_W-1:0] start, base, byte_addr;
   mode_t             mode;
   logic              wide;

   scrn_regs #(.ADDR_W(ADDR_W)) u_regs (
      .clk(clk), .rst_n(rst_n), .we(reg_we), .off(reg_off),
      .wdata(reg_wdata), .start(start), .mode(mode)
   );

   scrn_mode_dec #(.ADDR_W(ADDR_W)) u_dec (
      .mode(mode), .base(base), .wide(wide)
   );

   scrn_addr_ctr #(
      .ADDR_W(ADDR_W), .WRAP_LSB(WRAP_LSB), .STEP(STEP), .HCNT_W(HCNT_W),
      .H_ACTIVE(H_ACTIVE), .LOAD_HPOS(LOAD_HPOS)
   ) u_ctr (
      .clk(clk), .rst_n(rst_n), .h_count(h_count), .hsync(hsync),
      .frame_end(frame_end), .row_last(row_last), .wide(wide),
      .base(base), .start(start), .byte_addr(byte_addr)
   );

   // R4: per-bit merge of the row index into the byte address
   for (genvar i = 0; i < ADDR_W; i++) begin : g_merge
      if (i < ROW_W) begin : g_or
         assign rd_addr[i] = byte_addr[i] | char_row[i];
      end else begin : g_pass
         assign rd_addr[i] = byte_addr[i];
      end
   end
endmodule

// File: tb/sim_scrn_addr_gen.sv
`timescale 1ns/1ps
module sim_scrn_addr_gen;
   logic       clk = 0;
   logic       rst_n = 0;
   logic       reg_we = 0;
   logic [3:0] reg_off = 0;
   logic [7:0] reg_wdata = 0;
   logic [9:0] h_count = 10'd700;
   logic       hsync = 0, frame_end = 0, row_last = 0;
   logic [3:0] char_row = 0;
   logic [14:0] rd_addr;

   int tests = 0, fails = 0;

   always #2.5 clk = ~clk;

   scrn_addr_gen u0 (
      .clk(clk), .rst_n(rst_n), .reg_we(reg_we), .reg_off(reg_off),
      .reg_wdata(reg_wdata), .h_count(h_count), .hsync(hsync),
      .frame_end(frame_end), .row_last(row_last), .char_row(char_row),
      .rd_addr(rd_addr)
   );

   task automatic chk(input string req, input logic [14:0] exp);
      tests++;
      if (rd_addr !== exp) begin
         fails++;
         $display("FAIL %s: rd_addr=%h expected=%h", req, rd_addr, exp);
      end
   endtask

   task automatic cyc(input int h, input logic hs, input logic fe, input logic rl);
      h_count = h[9:0]; hsync = hs; frame_end = fe; row_last = rl;
      @(posedge clk); #1;
      h_count = 10'd700; hsync = 0; frame_end = 0; row_last = 0;
   endtask

   task automatic wr(input logic [3:0] off, input logic [7:0] d);
      reg_we = 1; reg_off = off; reg_wdata = d;
      @(posedge clk); #1;
      reg_we = 0;
   endtask

   task automatic frame_load();
      cyc(760, 0, 1, 0);
   endtask

   task automatic t_reset();
      chk("R1 reset address", 15'h0000);
      frame_load();
      chk("R1 load of reset start", 15'h0000);
      cyc(0, 0, 0, 0);
      chk("R1 mode 0 after reset folds to 0x3000", 15'h3008);
   endtask

   task automatic t_regs();
      wr(4'd3, 8'h18);
      wr(4'd2, 8'hE0);
      chk("R10 start write leaves address", 15'h3008);
      frame_load();
      chk("R9 both start fields", 15'h31C0);
      wr(4'd2, 8'h20);
      frame_load();
      chk("R9 low write keeps high field", 15'h3040);
      wr(4'd3, 8'hC5);
      frame_load();
      chk("R9 high write uses bits 5:0 only", 15'h0A40);
   endtask

   task automatic t_narrow();
      wr(4'd3, 8'h18); wr(4'd2, 8'h00);
      frame_load();
      for (int h = 0; h < 16; h++) cyc(h, 0, 0, 0);
      chk("R5 two steps over 16 counts", 15'h3010);
      cyc(632, 0, 0, 0);
      chk("R5 step at last active phase", 15'h3018);
      cyc(636, 0, 0, 0);
      chk("R5 no step off phase", 15'h3018);
      cyc(640, 0, 0, 0);
      chk("R5 no step at active limit", 15'h3018);
   endtask

   task automatic t_wide();
      wr(4'd7, 8'h20);
      frame_load();
      cyc(0, 0, 0, 0);
      chk("R6 no step at phase 0", 15'h3000);
      cyc(8, 0, 0, 0);
      chk("R6 step at phase 8", 15'h3008);
      cyc(16, 0, 0, 0);
      cyc(24, 0, 0, 0);
      chk("R6 one step per 16 counts", 15'h3010);
      cyc(648, 0, 0, 0);
      chk("R6 no step beyond active width", 15'h3010);
   endtask

   task automatic t_hsync();
      wr(4'd7, 8'h00);
      frame_load();
      cyc(0, 0, 0, 0); cyc(8, 0, 0, 0);
      cyc(700, 1, 0, 0);
      chk("R3 restore from row start", 15'h3000);
      cyc(0, 0, 0, 0); cyc(8, 0, 0, 0);
      cyc(700, 1, 0, 1);
      chk("R3 last line keeps byte address", 15'h3010);
      cyc(0, 0, 0, 0);
      cyc(700, 1, 0, 0);
      chk("R3 row start advanced", 15'h3010);
   endtask

   task automatic t_wrap();
      logic [14:0] bases [8];
      bases = '{15'h3000, 15'h3000, 15'h3000, 15'h4000,
                15'h5800, 15'h5800, 15'h6000, 15'h5800};
      wr(4'd3, 8'h03); wr(4'd2, 8'hE0);
      frame_load();
      cyc(0, 0, 0, 0);
      chk("R7 fold below 0x0800 keeps low bits", 15'h37C8);
      wr(4'd3, 8'h3F);
      for (int m = 0; m < 8; m++) begin
         wr(4'd7, 8'(m << 3));
         frame_load();
         for (int k = 0; k < 7; k++) cyc(m >= 4 ? 8 : 0, 0, 0, 0);
         if (m == 0) chk("R7 no fold at 0x7FF8", 15'h7FF8);
         cyc(m >= 4 ? 8 : 0, 0, 0, 0);
         chk($sformatf("R8 base for mode %0d", m), bases[m]);
      end
   endtask

   task automatic t_row();
      char_row = 4'd5; #1;
      chk("R4 row index merged", 15'h5805);
      char_row = 4'd0; #1;
      chk("R4 row index removed", 15'h5800);
   endtask

   task automatic t_collide();
      frame_load();
      reg_we = 1; reg_off = 4'd3; reg_wdata = 8'h10;
      cyc(760, 0, 1, 0);
      reg_we = 0;
      chk("R10 load in write cycle uses old start", 15'h7FC0);
      frame_load();
      chk("R10 new start at next load", 15'h21C0);
   endtask

   task automatic t_loadpos();
      wr(4'd3, 8'h18);
      cyc(752, 0, 1, 0);
      chk("R2 no load at other position", 15'h21C0);
      cyc(760, 0, 0, 0);
      chk("R2 no load without frame end", 15'h21C0);
      cyc(760, 0, 1, 0);
      chk("R2 load at position", 15'h31C0);
      wr(4'd5, 8'hFF);
      wr(4'd3, 8'h18);
      frame_load();
      chk("R9 other offset ignored", 15'h31C0);
   endtask

   initial begin
      repeat (100000) @(posedge clk);
      fails++;
      $display("FAIL watchdog: expired, expected completion");
      $display("  [TB] %0d tests run, %0d failed", tests, fails);
      $finish;
   end

   initial begin
      repeat (3) @(posedge clk);
      #1 rst_n = 1;
      t_reset();
      t_regs();
      t_narrow();
      t_wide();
      t_hsync();
      t_wrap();
      t_row();
      t_collide();
      t_loadpos();
      $display("  [TB] %0d tests run, %0d failed", tests, fails);
      $finish;
   end
endmodule